// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. Software-side logic writes a character into a one-entry holding register with a single-cycle strobe. The transmitter then moves it into a shift register and sends one frame on `txd`. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then one high stop bit. A free-running baud tick from outside paces the line. Each bit lasts 16 ticks in normal mode and 8 ticks in fast mode.

Because of the holding register, the next character can be written while the current frame is still on the line, and frames then follow each other with no gap. Two status flags follow the buffer state, each with a level interrupt request gated by its own enable. The empty flag shows that the holding register can take a character. The done flag shows that the line has gone quiet after a frame. Clearing the transmit enable is a soft stop: characters already committed are still sent, and later characters wait for the enable to return.

Top module: `serial_tx_buffered`

## Requirements
- R1: After a synchronous active-low reset, `txd` is 1, `flag_empty` is 1, `flag_done` is 0, and both interrupt requests are 0.
- R2: A frame is one start bit of value 0, then the data bits with bit 0 first, then one stop bit of value 1. `txd` is 1 whenever no frame is being sent.
- R3: When `cfg_nine` is 1 at frame start, a ninth data bit follows data bit 7. That bit is the `wr_b8` value captured together with the character's write strobe.
- R4: Each bit lasts 16 baud ticks when `cfg_fast` is 0 and 8 baud ticks when it is 1. `cfg_fast` and `cfg_nine` are sampled when a frame starts, and changing them mid-frame does not alter that frame.
- R5: A write strobe makes `flag_empty` 0 from the next cycle. When the character moves into an idle shift register, `flag_empty` returns to 1 and the start bit begins one cycle after the write.
- R6: A character written while a frame is in progress starts its start bit in the cycle right after the previous stop bit ends, so the line does not idle in between.
- R7: `flag_done` becomes 1 at the end of a stop bit only when no further frame starts in that cycle. It stays 0 during the stop bit and between frames sent back to back.
- R8: `flag_done` stays set until `done_clr` or `done_ack` is 1 for a cycle, and it reads 0 in the following cycle.
- R9: `irq_empty` is high whenever both `flag_empty` and `ie_empty` are 1. `irq_done` is high whenever both `flag_done` and `ie_done` are 1.
- R10: Dropping `tx_on` while a frame is being sent and a character is held lets both of them go out completely before the line idles.
- R11: While `tx_on` is 0 and nothing is held over from a drain, a written character is kept but not sent. A second write replaces it, and it is sent once `tx_on` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times (or 8 times in fast mode) the bit rate |
| tx_on | input | 1 | Transmit enable, with soft stop when dropped |
| cfg_nine | input | 1 | 1 selects 9 data bits per frame |
| cfg_fast | input | 1 | 1 selects 8 ticks per bit instead of 16 |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character data written with `wr_en` |
| wr_b8 | input | 1 | Ninth data bit written with `wr_en` |
| done_clr | input | 1 | Write-one clear of `flag_done` |
| done_ack | input | 1 | Interrupt acknowledge that clears `flag_done` |
| ie_empty | input | 1 | Enable for `irq_empty` |
| ie_done | input | 1 | Enable for `irq_done` |
| txd | output | 1 | Serial line output, idle high |
| flag_empty | output | 1 | Holding register can take a character |
| flag_done | output | 1 | Line went quiet after a completed frame |
| irq_empty | output | 1 | Level interrupt request for the empty flag |
| irq_done | output | 1 | Level interrupt request for the done flag |

## Verification
A wrong shift register or bit counter shows up on `txd` within one bit time. It appears as a misplaced data bit, a missing ninth bit, or a stop bit that is low or of the wrong length, and the bench decodes every frame at bit centres. A fault in the holding-register handover shows up as a gap or an extra done pulse between frames sent back to back, or, in the drain case, as a missing second frame. A stuck empty or done flag is visible on the flag and interrupt ports on the cycle after the write, the clear or the end of the stop bit.

// File: rtl/sertx_pkg.sv
// Shared constants and helpers for the buffered serial transmitter.
// Assumes one start bit and one stop bit per frame.
package sertx_pkg;

    // Start bit, stop bit and the optional ninth bit around the data field.
    localparam int unsigned SERTX_FRAME_EXTRA = 3;

    // Number of bit times a frame occupies on the line.
    function automatic int unsigned sertx_frame_bits(input int unsigned dw, input logic nine);
        return dw + (nine ? 32'd3 : 32'd2);
    endfunction

endpackage

// File: rtl/sertx_holdreg.sv
// One-entry holding register in front of the shift register.
// A write always lands, even when the register is full: the new
// character replaces the old one. A take empties the register unless
// a write arrives in the same cycle.
module sertx_holdreg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_b8,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              b8
);

    // Capture written characters and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            b8   <= 1'b0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
            b8   <= wr_b8;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R5
    hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full);

    // R5
    hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> !full);

endmodule

// File: rtl/sertx_shifter.sv
// Frame shifter with its own bit pacer.
// On load it builds the whole frame (start, data, optional ninth bit,
// stop) in one register and shifts it out bit 0 first. Each bit lasts
// SLOW_TICKS or FAST_TICKS baud ticks. The speed and the frame length
// are latched at load. Assumes load is only raised when idle or in
// the frame_end cycle.
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SLOW_TICKS = 16,
    parameter int unsigned FAST_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_b8,
    input  logic              ld_nine,
    input  logic              ld_fast,
    output logic              busy,
    output logic              frame_end,
    output logic              txd
);

    localparam int unsigned FW = DATA_W + SERTX_FRAME_EXTRA;
    localparam int unsigned CW = $clog2(SLOW_TICKS);
    localparam int unsigned BW = $clog2(FW + 1);
    localparam logic [BW-1:0] LEN_NINE  = BW'(sertx_frame_bits(DATA_W, 1'b1));
    localparam logic [BW-1:0] LEN_EIGHT = BW'(sertx_frame_bits(DATA_W, 1'b0));
    localparam logic [CW-1:0] LAST_SLOW = CW'(SLOW_TICKS - 1);
    localparam logic [CW-1:0] LAST_FAST = CW'(FAST_TICKS - 1);

    logic [FW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic [BW-1:0] left;
    logic          fast_q;
    logic [CW-1:0] tick_last;
    logic          bit_end;
    logic [FW-1:0] frame_img;

    // Last tick index of the current bit, from the speed latched at load.
    always_comb tick_last = fast_q ? LAST_FAST : LAST_SLOW;

    // A bit ends on the tick that completes its tick count.
    always_comb bit_end = busy && baud_tick && (cnt == tick_last);

    // The frame ends with the last bit; the holder may reload here.
    always_comb frame_end = bit_end && (left == BW'(1));

    // Frame image: stop, optional ninth bit, data, start at bit 0.
    always_comb begin
        if (ld_nine) frame_img = {1'b1, ld_b8, ld_data, 1'b0};
        else         frame_img = {1'b1, 1'b1, ld_data, 1'b0};
    end

    // Load, pace and shift the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            shreg  <= '1;
            cnt    <= '0;
            left   <= '0;
            fast_q <= 1'b0;
        end else if (load) begin
            busy   <= 1'b1;
            shreg  <= frame_img;
            cnt    <= '0;
            left   <= ld_nine ? LEN_NINE : LEN_EIGHT;
            fast_q <= ld_fast;
        end else if (bit_end) begin
            shreg <= {1'b1, shreg[FW-1:1]};
            cnt   <= '0;
            left  <= left - BW'(1);
            if (left == BW'(1)) busy <= 1'b0;
        end else if (busy && baud_tick) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Line drive: the current frame bit, high when idle.
    always_comb txd = busy ? shreg[0] : 1'b1;

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R4
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= tick_last));

    // R6
    chain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && load) |=> (busy && !txd));

endmodule

// File: rtl/sertx_ctl.sv
// Enable handling, the done flag and the interrupt requests.
// A fall of tx_on while a character is held marks that character as
// owed, so it is still sent. The done flag is set at a frame end that
// is not followed by a new frame; setting takes priority over clearing.
module sertx_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_on,
    input  logic hold_full,
    input  logic load,
    input  logic frame_end,
    input  logic done_clr,
    input  logic done_ack,
    input  logic ie_empty,
    input  logic ie_done,
    output logic send_ok,
    output logic flag_done,
    output logic irq_empty,
    output logic irq_done
);

    logic en_q;
    logic owed;
    logic en_fall;

    always_comb en_fall = en_q && !tx_on;

    // Remember the enable and whether a held character must still go out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            owed <= 1'b0;
        end else begin
            en_q <= tx_on;
            if (en_fall && hold_full && !load) owed <= 1'b1;
            else if (load || tx_on)            owed <= 1'b0;
        end
    end

    // A load may start while enabled, in the cycle the enable falls, or while draining.
    always_comb send_ok = tx_on || owed || (en_q && hold_full);

    // Done flag: set by an unfollowed frame end, cleared by write-one or acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_done <= 1'b0;
        else if (frame_end && !load)    flag_done <= 1'b1;
        else if (done_clr || done_ack)  flag_done <= 1'b0;
    end

    // Level interrupt requests.
    always_comb irq_empty = !hold_full && ie_empty;
    always_comb irq_done  = flag_done && ie_done;

    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !load) |=> flag_done);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_done && !done_clr && !done_ack) |=> flag_done);

    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_done && (done_clr || done_ack) && !frame_end) |=> !flag_done);

    // R11
    parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_on && !en_q && !owed) |-> !load);

endmodule

// File: rtl/serial_tx_buffered.sv
// Buffered asynchronous serial transmitter: holding register, frame
// shifter and control. Assumes baud_tick is a one-cycle pulse from an
// external rate generator. The holding register hands a character
// over when the shifter is idle or finishing a frame.
module serial_tx_buffered #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SLOW_TICKS = 16,
    parameter int unsigned FAST_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_on,
    input  logic              cfg_nine,
    input  logic              cfg_fast,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_b8,
    input  logic              done_clr,
    input  logic              done_ack,
    input  logic              ie_empty,
    input  logic              ie_done,
    output logic              txd,
    output logic              flag_empty,
    output logic              flag_done,
    output logic              irq_empty,
    output logic              irq_done
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              hold_b8;
    logic              busy;
    logic              frame_end;
    logic              send_ok;
    logic              load;

    // Handover: a held character enters the shifter when it is free.
    always_comb load = hold_full && send_ok && (!busy || frame_end);

    // Empty flag mirrors the holding register occupancy.
    always_comb flag_empty = !hold_full;

    sertx_holdreg #(.DATA_W(DATA_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_b8   (wr_b8),
        .take    (load),
        .full    (hold_full),
        .data    (hold_data),
        .b8      (hold_b8)
    );

    sertx_shifter #(
        .DATA_W     (DATA_W),
        .SLOW_TICKS (SLOW_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .load      (load),
        .ld_data   (hold_data),
        .ld_b8     (hold_b8),
        .ld_nine   (cfg_nine),
        .ld_fast   (cfg_fast),
        .busy      (busy),
        .frame_end (frame_end),
        .txd       (txd)
    );

    sertx_ctl i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_on     (tx_on),
        .hold_full (hold_full),
        .load      (load),
        .frame_end (frame_end),
        .done_clr  (done_clr),
        .done_ack  (done_ack),
        .ie_empty  (ie_empty),
        .ie_done   (ie_done),
        .send_ok   (send_ok),
        .flag_done (flag_done),
        .irq_empty (irq_empty),
        .irq_done  (irq_done)
    );

    // R5
    empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !flag_empty);

    // R10
    drain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_end) |=> busy);

endmodule

// File: tb/test_serial_tx_buffered.sv
// Self-checking bench: decodes every frame at bit centres and sweeps
// all 256 characters plus a grid of modes and patterns.
module test_serial_tx_buffered;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       baud_tick;
    logic       tx_on;
    logic       cfg_nine;
    logic       cfg_fast;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       wr_b8;
    logic       done_clr;
    logic       done_ack;
    logic       ie_empty;
    logic       ie_done;
    logic       txd;
    logic       flag_empty;
    logic       flag_done;
    logic       irq_empty;
    logic       irq_done;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  tick_div = 1;
    int  tcnt = 0;
    bit  finished = 1'b0;

    logic [7:0] rd;
    logic       rb;
    logic       rs;
    logic       rm;

    always #10 clk = ~clk;

    serial_tx_buffered i_serial_tx_buffered (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .tx_on      (tx_on),
        .cfg_nine   (cfg_nine),
        .cfg_fast   (cfg_fast),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_b8      (wr_b8),
        .done_clr   (done_clr),
        .done_ack   (done_ack),
        .ie_empty   (ie_empty),
        .ie_done    (ie_done),
        .txd        (txd),
        .flag_empty (flag_empty),
        .flag_done  (flag_done),
        .irq_empty  (irq_empty),
        .irq_done   (irq_done)
    );

    // Baud tick source: every cycle, or one cycle in tick_div.
    always @(negedge clk) begin
        if (tick_div <= 1) begin
            baud_tick = 1'b1;
        end else begin
            baud_tick = (tcnt == 0);
            tcnt = (tcnt + 1) % tick_div;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_char(input logic [7:0] d, input logic b8);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_b8 = b8;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr(input bit use_ack);
        @(negedge clk);
        if (use_ack) done_ack = 1'b1; else done_clr = 1'b1;
        @(negedge clk);
        done_ack = 1'b0; done_clr = 1'b0;
        chk(use_ack ? "R8 cleared by ack" : "R8 cleared by write-one", flag_done, 0);
    endtask

    // Decode one frame at bit centres; returns on the negedge one bit after stop start.
    task automatic rx_frame(input int tpb, input bit nine,
                            output logic [7:0] d, output logic b8,
                            output logic stopv, output logic dn_mid);
        int guard = 0;
        while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
        repeat (tpb / 2) @(negedge clk);
        chk("R2 start bit low", txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (tpb) @(negedge clk);
            d[i] = txd;
        end
        b8 = 1'b0;
        if (nine) begin
            repeat (tpb) @(negedge clk);
            b8 = txd;
        end
        repeat (tpb) @(negedge clk);
        stopv  = txd;
        dn_mid = flag_done;
        repeat (tpb / 2) @(negedge clk);
    endtask

    task automatic wait_done();
        int guard = 0;
        while (flag_done !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tx_on = 1'b1; cfg_nine = 1'b0; cfg_fast = 1'b1;
        wr_en = 1'b0; wr_data = '0; wr_b8 = 1'b0; done_clr = 1'b0; done_ack = 1'b0;
        ie_empty = 1'b0; ie_done = 1'b0; baud_tick = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 txd idle", txd, 1);
        chk("R1 empty set", flag_empty, 1);
        chk("R1 done clear", flag_done, 0);
        chk("R1 irq_empty low", irq_empty, 0);
        chk("R1 irq_done low", irq_done, 0);

        // R5 / R9 handover timing on the first character
        ie_empty = 1'b1; ie_done = 1'b1;
        @(negedge clk);
        chk("R9 irq_empty with flag and enable", irq_empty, 1);
        put_char(8'h5A, 1'b0);
        chk("R5 empty drops after write", flag_empty, 0);
        chk("R9 irq_empty follows flag", irq_empty, 0);
        @(negedge clk);
        chk("R5 empty back after handover", flag_empty, 1);
        chk("R5 start bit one cycle after write", txd, 0);
        rx_frame(8, 1'b0, rd, rb, rs, rm);
        chk("R2 data 5A", rd, 8'h5A);
        chk("R9 irq_done with flag and enable", irq_done, 1);
        pulse_clr(1'b1);
        chk("R9 irq_done follows flag", irq_done, 0);
        ie_empty = 1'b0; ie_done = 1'b0;

        // R2 / R7 / R8 exhaustive over all characters, 8-bit fast mode
        for (int v = 0; v < 256; v++) begin
            put_char(v[7:0], 1'b0);
            rx_frame(8, 1'b0, rd, rb, rs, rm);
            chk("R2 exhaustive data", rd, v[7:0]);
            chk("R2 stop bit high", rs, 1);
            chk("R7 done low during stop", rm, 0);
            chk("R7 done after stop", flag_done, 1);
            chk("R2 idle high after frame", txd, 1);
            pulse_clr(v[0]);
        end

        // R3 / R4 mode grid with patterns and ninth bit
        for (int m = 0; m < 4; m++) begin
            cfg_nine = m[0]; cfg_fast = m[1];
            for (int p = 0; p < 8; p++) begin
                logic [7:0] pat;
                pat = 8'h01 << p;
                pat = (p[0]) ? ~pat : pat ^ 8'h3C;
                put_char(pat, p[1]);
                rx_frame(m[1] ? 8 : 16, m[0], rd, rb, rs, rm);
                chk("R3 data in mode grid", rd, pat);
                if (m[0]) chk("R3 ninth bit from write", rb, p[1]);
                chk("R2 stop in mode grid", rs, 1);
                chk("R7 done after grid frame", flag_done, 1);
                pulse_clr(1'b0);
            end
        end
        cfg_nine = 1'b0;

        // R4 bit length counted in baud ticks, speed latched at start
        tick_div = 4;
        for (int f = 0; f < 2; f++) begin
            int tpb;
            int cnt;
            int guard;
            tpb = f ? 8 : 16;
            cfg_fast = f[0];
            put_char(8'h00, 1'b0);
            guard = 0;
            while (txd !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
            cfg_fast = !f[0];
            cnt = 0;
            while (txd === 1'b0 && cnt < 5000) begin cnt++; @(negedge clk); end
            chk("R4 low time within tick window",
                (cnt >= (9 * tpb - 1) * 4 + 1) && (cnt <= 9 * tpb * 4), 1);
            wait_done();
            pulse_clr(1'b0);
        end
        tick_div = 1;
        cfg_fast = 1'b1;

        // R6 / R7 back-to-back frames
        put_char(8'hA5, 1'b0);
        fork
            begin
                rx_frame(8, 1'b0, rd, rb, rs, rm);
                chk("R6 first of pair", rd, 8'hA5);
                chk("R6 next start without gap", txd, 0);
                chk("R7 no done between frames", flag_done, 0);
                rx_frame(8, 1'b0, rd, rb, rs, rm);
                chk("R6 second of pair", rd, 8'h3C);
                chk("R7 done after last frame", flag_done, 1);
            end
            begin
                repeat (4) @(negedge clk);
                put_char(8'h3C, 1'b0);
                chk("R5 empty low while held", flag_empty, 0);
            end
        join
        pulse_clr(1'b0);

        // R10 drain on disable
        put_char(8'h81, 1'b0);
        fork
            begin
                rx_frame(8, 1'b0, rd, rb, rs, rm);
                chk("R10 current frame completes", rd, 8'h81);
                rx_frame(8, 1'b0, rd, rb, rs, rm);
                chk("R10 held frame completes", rd, 8'h42);
                chk("R10 done after drain", flag_done, 1);
            end
            begin
                repeat (3) @(negedge clk);
                put_char(8'h42, 1'b0);
                repeat (10) @(negedge clk);
                tx_on = 1'b0;
            end
        join
        pulse_clr(1'b0);

        // R11 parked writes while disabled, replacement, release
        put_char(8'h11, 1'b0);
        begin
            int lows;
            lows = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            chk("R11 line idle while disabled", lows, 0);
        end
        chk("R11 character held while disabled", flag_empty, 0);
        chk("R11 no done while disabled", flag_done, 0);
        put_char(8'h22, 1'b0);
        tx_on = 1'b1;
        rx_frame(8, 1'b0, rd, rb, rs, rm);
        chk("R11 replaced character sent on enable", rd, 8'h22);
        chk("R11 done after release", flag_done, 1);
        repeat (20) @(negedge clk);
        chk("R11 only one frame sent", txd, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule